// File: doc/BRIEF.md
# Periodic Test-Frame Playback Sequencer

This block replays a fixed set of recorded test frames as a stream of transmit samples. It holds eight frames of 512 samples each in a constant table. A tick input marks each sample slot. A period timer counts these ticks, and each time the timer expires the block starts the next frame. A frame selector steps through the eight frames in turn and goes back to the first after the last.

Host software sets the spacing between frames through a period word that comes from a control register. The block reads that word only when a period ends, so a period already running is never shortened or stretched. A programmed value below the frame length is raised to the frame length, so a frame is never cut short. During the part of each period after the frame has been sent, the output is zero and the valid strobe stays low.

Top module: `pbs_playback_seq`

## Requirements
- R1: While `rst_i` is high, and in the first cycle after it goes low, `smp_valid_o` is 0 and `smp_data_o` is 0. After reset, playback starts at frame 0, sample 0, on the first tick.
- R2: Sample k (0..511) of frame m (0..7) has the value {m[2:0], 4'b0101, k[8:0]}. So bits 15:13 hold the frame number, bits 12:9 hold the pattern 0101, and bits 8:0 hold the sample index.
- R3: A tick that lands on timer position p, with p < 512, gives `smp_valid_o` = 1 in the next clock cycle only. In that cycle `smp_data_o` carries sample p of the current frame.
- R4: In every cycle where `smp_valid_o` is 0, `smp_data_o` is 0. A tick that lands on timer position p ≥ 512 gives no valid strobe.
- R5: With an effective period of P, the timer counts ticks at positions 0..P-1 and then goes back to 0. Frame starts are therefore exactly P ticks apart.
- R6: A period word below 512, including 0, acts as a period of 512. Values from 512 up to 2^24-1 are used unchanged.
- R7: On the tick that ends a period, the frame number increases by one. After frame 7 it goes back to 0.
- R8: The period word is sampled on the tick that ends a period, and also during reset. A change between these points takes effect only from the next period.
- R9: In cycles without a tick, the timer position and the frame number hold their values, and no valid strobe is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Sample-slot enable, one clock per sample |
| period_i | input | 24 | Period length in ticks, from the control register |
| smp_valid_o | output | 1 | High for one clock per played sample |
| smp_data_o | output | 16 | Played sample, zero when not valid |

## Verification
On every cycle, the assertions check the following:
- a valid strobe is always preceded by a tick;
- the data is zero whenever valid is low;
- the effective period never drops below the frame length;
- the period changes only at a period end;
- the frame number steps by one, or wraps from 7 to 0, at each period end and at no other time.

Some behaviour can only be shown by the bench scenarios, which compare the outputs with a reference model on every clock:
- the exact sample contents;
- that frame starts are spaced exactly P ticks apart;
- that a new period value waits for the boundary;
- that sparse or stopped ticks freeze the sequence.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int NUM_MSG  = 8;
    localparam int MSG_LEN  = 512;
    localparam int SAMP_W   = 16;
    localparam int PERIOD_W = 24;
    localparam int MSG_W    = $clog2(NUM_MSG);
    localparam int IDX_W    = $clog2(MSG_LEN);
    localparam int TAG_W    = SAMP_W - MSG_W - IDX_W;

    // Request from the timing side to the sample table
    typedef struct packed {
        logic             fire;
        logic [MSG_W-1:0] msg;
        logic [IDX_W-1:0] idx;
    } play_req_t;

    // Raise short periods to the frame length
    function automatic logic [PERIOD_W-1:0] clamp_period(input logic [PERIOD_W-1:0] p);
        if (p < PERIOD_W'(MSG_LEN))
            return PERIOD_W'(MSG_LEN);
        return p;
    endfunction

    // Constant frame contents: frame number, fixed tag, sample index
    function automatic logic [SAMP_W-1:0] msg_word(input logic [MSG_W-1:0] m,
                                                   input logic [IDX_W-1:0] k);
        logic [SAMP_W-1:0] w;
        w = SAMP_W'(k);
        w = w | (SAMP_W'(TAG_W'(5)) << IDX_W);
        w = w | (SAMP_W'(m) << (SAMP_W - MSG_W));
        return w;
    endfunction

endpackage

// File: rtl/pbs_period_timer.sv
module pbs_period_timer
    import pbs_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic [PERIOD_W-1:0] pos_o,
    output logic [PERIOD_W-1:0] act_period_o,
    output logic                wrap_o
);

    logic [PERIOD_W-1:0] pos_q;
    logic [PERIOD_W-1:0] act_q;
    logic                last_pos;

    assign last_pos = (pos_q == act_q - PERIOD_W'(1));
    assign wrap_o   = tick_i && last_pos;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos_q <= '0;
            act_q <= clamp_period(period_i);
        end else if (wrap_o) begin
            pos_q <= '0;
            act_q <= clamp_period(period_i);
        end else if (tick_i) begin
            pos_q <= pos_q + PERIOD_W'(1);
        end
    end

    assign pos_o        = pos_q;
    assign act_period_o = act_q;

endmodule

// File: rtl/pbs_msg_select.sv
module pbs_msg_select
    import pbs_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             adv_i,
    output logic [MSG_W-1:0] msg_o
);

    localparam logic [MSG_W-1:0] LAST = MSG_W'(NUM_MSG - 1);

    logic [MSG_W-1:0] msg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            msg_q <= '0;
        else if (adv_i)
            msg_q <= (msg_q == LAST) ? '0 : msg_q + MSG_W'(1);
    end

    assign msg_o = msg_q;

endmodule

// File: rtl/pbs_sample_rom.sv
module pbs_sample_rom
    import pbs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  play_req_t         req_i,
    output logic              valid_o,
    output logic [SAMP_W-1:0] data_o
);

    logic              valid_q;
    logic [SAMP_W-1:0] data_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= req_i.fire;
            data_q  <= req_i.fire ? msg_word(req_i.msg, req_i.idx) : '0;
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;

endmodule

// File: rtl/pbs_playback_seq.sv
module pbs_playback_seq
    import pbs_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                smp_valid_o,
    output logic [SAMP_W-1:0]   smp_data_o
);

    logic [PERIOD_W-1:0] pos;
    logic [PERIOD_W-1:0] act_period;
    logic                wrap_evt;
    logic [MSG_W-1:0]    msg_sel;
    play_req_t           req;

    pbs_period_timer u_timer (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .tick_i       (tick_i),
        .period_i     (period_i),
        .pos_o        (pos),
        .act_period_o (act_period),
        .wrap_o       (wrap_evt)
    );

    pbs_msg_select u_sel (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .adv_i (wrap_evt),
        .msg_o (msg_sel)
    );

    always_comb begin
        req.fire = tick_i && (pos < PERIOD_W'(MSG_LEN));
        req.msg  = msg_sel;
        req.idx  = pos[IDX_W-1:0];
    end

    pbs_sample_rom u_rom (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .req_i   (req),
        .valid_o (smp_valid_o),
        .data_o  (smp_data_o)
    );

endmodule

// File: rtl/pbs_playback_chk.sv
module pbs_playback_chk
    import pbs_pkg::*;
(
    input logic                clk_i,
    input logic                rst_i,
    input logic                tick_i,
    input logic                smp_valid_o,
    input logic [SAMP_W-1:0]   smp_data_o,
    input logic [MSG_W-1:0]    msg_sel,
    input logic [PERIOD_W-1:0] act_period,
    input logic                wrap_evt
);

    localparam logic [MSG_W-1:0] LAST = MSG_W'(NUM_MSG - 1);

    AST_VALID_AFTER_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_valid_o |-> $past(tick_i));                                    // R3

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !smp_valid_o |-> (smp_data_o == '0));                              // R4

    AST_PERIOD_FLOOR: assert property (@(posedge clk_i) disable iff (rst_i)
        act_period >= PERIOD_W'(MSG_LEN));                                 // R6

    AST_PERIOD_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(act_period) |-> $past(wrap_evt));                         // R8

    AST_MSG_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(msg_sel) |-> $past(wrap_evt));                            // R9

    AST_MSG_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(wrap_evt) && $past(msg_sel) == LAST) |-> (msg_sel == '0));  // R7

    AST_MSG_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(wrap_evt) && $past(msg_sel) != LAST)
            |-> (msg_sel == $past(msg_sel) + MSG_W'(1)));                  // R7

endmodule

bind pbs_playback_seq pbs_playback_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .tick_i      (tick_i),
    .smp_valid_o (smp_valid_o),
    .smp_data_o  (smp_data_o),
    .msg_sel     (msg_sel),
    .act_period  (act_period),
    .wrap_evt    (wrap_evt)
);

// File: tb/pbs_playback_seq_bench.sv
module pbs_playback_seq_bench;

    logic        clk = 1'b0;
    logic        rst_i;
    logic        tick_i;
    logic [23:0] period_i;
    logic        smp_valid_o;
    logic [15:0] smp_data_o;

    always #10 clk = ~clk;

    pbs_playback_seq u_pbs_playback_seq (
        .clk_i       (clk),
        .rst_i       (rst_i),
        .tick_i      (tick_i),
        .period_i    (period_i),
        .smp_valid_o (smp_valid_o),
        .smp_data_o  (smp_data_o)
    );

    int    n_checks = 0;
    int    n_bad    = 0;
    int    cyc      = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    // reference model state
    int m_pos, m_msg, m_act;
    bit exp_valid;
    int exp_data;

    int starts_msg[$];
    int starts_cyc[$];

    function automatic int ref_clamp(int p);
        return (p < 512) ? 512 : p;
    endfunction

    task automatic check(string req, bit ok, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_i) begin
            m_pos = 0; m_msg = 0; m_act = ref_clamp(int'(period_i));
            exp_valid = 0; exp_data = 0;
        end else begin
            exp_valid = tick_i && (m_pos < 512);
            exp_data  = exp_valid ? ((m_msg << 13) | (5 << 9) | m_pos) : 0;
            if (tick_i) begin
                if (m_pos == m_act - 1) begin
                    m_pos = 0;
                    m_msg = (m_msg + 1) % 8;
                    m_act = ref_clamp(int'(period_i));
                end else begin
                    m_pos++;
                end
            end
        end
        cyc++;
        @(negedge clk);
        check(cur_req, (smp_valid_o == exp_valid) && (int'(smp_data_o) == exp_data),
              {15'd0, smp_valid_o, smp_data_o}, {15'd0, exp_valid, exp_data[15:0]});
        if (smp_valid_o && smp_data_o[8:0] == 9'd0) begin
            starts_msg.push_back(int'(smp_data_o[15:13]));
            starts_cyc.push_back(cyc);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        rst_i = 1; tick_i = 1; period_i = 24'd0;
        cur_req = "R1";
        repeat (4) step();
        // R1: outputs idle in reset even with tick high
        check("R1", smp_valid_o == 0 && smp_data_o == 0, {15'd0, smp_valid_o, smp_data_o}, 0);
        rst_i = 0;

        // R2 R3 R6 R7: period word 0 acts as 512, back-to-back frames
        cur_req = "R2";
        repeat (9 * 512) step();
        check("R7", starts_msg.size() == 9, starts_msg.size(), 9);
        for (int i = 0; i < 9 && i < starts_msg.size(); i++)
            check("R7", starts_msg[i] == i % 8, starts_msg[i], i % 8);
        for (int i = 1; i < 9 && i < starts_cyc.size(); i++)
            check("R6", starts_cyc[i] - starts_cyc[i-1] == 512,
                  starts_cyc[i] - starts_cyc[i-1], 512);

        // R8 R5 R4: new period written mid-period, applies from next boundary
        starts_msg.delete(); starts_cyc.delete();
        period_i = 24'd700;
        cur_req = "R8";
        step();
        period_i = 24'd700;
        cur_req = "R5";
        repeat (2000) step();
        check("R8", starts_cyc.size() >= 3, starts_cyc.size(), 3);
        if (starts_cyc.size() >= 3) begin
            check("R8", starts_cyc[1] - starts_cyc[0] == 512, starts_cyc[1] - starts_cyc[0], 512);
            check("R5", starts_cyc[2] - starts_cyc[1] == 700, starts_cyc[2] - starts_cyc[1], 700);
        end

        // R9: sparse ticks, period 600
        period_i = 24'd600;
        cur_req = "R9";
        for (int i = 0; i < 4200; i++) begin
            tick_i = (i % 3 == 0);
            step();
        end
        // R9: ticks stopped, outputs stay idle
        tick_i = 0;
        repeat (50) step();

        // R6: short period word 5 is raised to 512
        starts_cyc.delete(); starts_msg.delete();
        period_i = 24'd5;
        tick_i = 1;
        cur_req = "R6";
        repeat (2500) step();
        if (starts_cyc.size() >= 3)
            check("R6", starts_cyc[2] - starts_cyc[1] == 512, starts_cyc[2] - starts_cyc[1], 512);
        else
            check("R6", 0, starts_cyc.size(), 3);

        // R1: reset mid-run, then restart from frame 0 sample 0
        rst_i = 1;
        cur_req = "R1";
        repeat (3) step();
        rst_i = 0;
        starts_msg.delete();
        step();
        check("R1", starts_msg.size() == 1 && starts_msg[0] == 0,
              starts_msg.size(), 1);
        repeat (20) step();

        summary();
    end

endmodule